// File: doc/BRIEF.md
# Chainable Serial Wiper Setting Loader

This block receives an 8-bit wiper setting over a three-wire serial link made of a serial clock, a data input and an active-low select. While select is low, each rising serial-clock edge shifts one data bit into a shift register, most significant bit first. When select returns high, the shifted byte is copied into the wiper register that drives the resistor ladder decoder. A select window that carried no clock edges leaves the wiper register as it was.

The bits that leave the top of the shift register appear on an open-drain serial output. Several copies can therefore share one select line, with each serial output feeding the next data input through a pull-up. One long frame then loads every device in the chain: the bytes sent first end up in the devices furthest down the chain.

All three serial inputs are asynchronous to the system clock. They are brought into the system clock domain by a two-flop synchroniser, and their edges are detected there.

Top module: `wiper_chain_loader`

## Requirements
- R1: After reset the wiper register holds midscale 0x80 and the serial output is released (`sdo_pull_low` = 0).
- R2: An 8-bit frame sent most significant bit first is copied into `wiper` once select returns high. `wiper` does not change while the frame is still open.
- R3: When more than 8 bits arrive in one select-low window, `wiper` receives the last 8 bits sent. The earlier bits are lost.
- R4: Rising serial-clock edges while select is high shift nothing. A later short frame commits the bits held before them plus the new bits.
- R5: A select-low window with no rising serial-clock edge leaves `wiper` unchanged.
- R6: `sdo_pull_low` is 0 whenever select is high. While select is low, `sdo_pull_low` equals the inverse of shift-register bit 7, and it is reloaded on each falling serial-clock edge and when select falls.
- R7: In a chain of two, a 16-bit frame loads its first byte into the far device and its second byte into the near device.
- R8: A frame of fewer than 8 bits commits the earlier shift-register contents moved up by the number of new bits, with the new bits in the low positions.
- R9: A rising serial-clock edge that reaches the synchroniser in the same system cycle as the release of select is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data input, asynchronous |
| cs_n | input | 1 | Active-low select, asynchronous |
| wiper | output | 8 | Committed wiper setting |
| sdo_pull_low | output | 1 | Open-drain enable for the serial output: 1 pulls the line low, 0 releases it |

## Verification
A shift and a select release can fall into the same synchronised cycle. The bench causes this by raising the serial clock and releasing select at the same system-clock instant, after a full byte has been sent. It then expects both chained devices to commit the contents they held before that edge, so the coincident bit appears in neither wiper. The same two-device chain, with random frame lengths from 0 to 20 bits, checks every commit against a bench model of the chain, alongside directed frames for overflow, empty windows and clocks sent while select is high.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

  typedef struct packed {
    logic sclk_rise;
    logic sclk_fall;
    logic cs_rise;
    logic cs_fall;
  } wpr_events_t;

  // Code for the centre tap of a ladder addressed by a w-bit word.
  function automatic int unsigned midscale(input int unsigned w);
    return 32'd1 << (w - 1);
  endfunction

endpackage

// File: rtl/wpr_sync.sv
module wpr_sync #(
  parameter int unsigned N      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST;
        else        stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/wpr_edge.sv
module wpr_edge #(
  parameter logic RST_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_LVL;
    else        prev_q <= d;
  end

  assign rise = d & ~prev_q;
  assign fall = ~d & prev_q;
endmodule

// File: rtl/wpr_shifter.sv
module wpr_shifter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_ev,
  input  logic             din,
  input  logic             sdo_load_ev,
  input  logic             sdo_release,
  output logic [WIDTH-1:0] shreg,
  output logic             sdo_pull_low
);
  function automatic logic [WIDTH-1:0] push_bit(input logic [WIDTH-1:0] cur,
                                                input logic b);
    return {cur[WIDTH-2:0], b};
  endfunction

  logic [WIDTH-1:0] sh_q;
  logic             pull_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (shift_ev) begin
      sh_q <= push_bit(sh_q, din);
    end
  end

  // Open drain: pull low for a 0 on top of the register, release otherwise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pull_q <= 1'b0;
    end else if (sdo_release) begin
      pull_q <= 1'b0;
    end else if (sdo_load_ev) begin
      pull_q <= ~sh_q[WIDTH-1];
    end
  end

  assign shreg        = sh_q;
  assign sdo_pull_low = pull_q;
endmodule

// File: rtl/wpr_commit.sv
module wpr_commit #(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] PRESET = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_ev,
  input  logic             cs_rise,
  input  logic [WIDTH-1:0] shreg,
  output logic             commit_ev,
  output logic [WIDTH-1:0] wiper
);
  logic             seen_q;
  logic [WIDTH-1:0] wiper_q;

  // A window counts only once it has captured at least one bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_q <= 1'b0;
    else if (cs_rise)  seen_q <= 1'b0;
    else if (shift_ev) seen_q <= 1'b1;
  end

  assign commit_ev = cs_rise & seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wiper_q <= PRESET;
    else if (commit_ev) wiper_q <= shreg;
  end

  assign wiper = wiper_q;
endmodule

// File: rtl/wiper_chain_loader.sv
module wiper_chain_loader #(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             sdi,
  input  logic             cs_n,
  output logic [WIDTH-1:0] wiper,
  output logic             sdo_pull_low
);
  import wpr_pkg::*;

  localparam logic [WIDTH-1:0] PRESET = WIDTH'(midscale(WIDTH));
  // Synchroniser lanes: {cs_n, sdi, sclk}; select idles high.
  localparam logic [2:0] SYNC_RST = 3'b100;

  logic [2:0]  sync_q;
  logic        sclk_sync;
  logic        sdi_sync;
  logic        cs_sync;
  wpr_events_t ev;
  logic        shift_ev;
  logic        sdo_load_ev;
  logic        commit_ev;
  logic [WIDTH-1:0] shreg;

  wpr_sync #(.N(3), .STAGES(SYNC_STAGES), .RST(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, sdi, sclk}),
    .q     (sync_q)
  );

  assign sclk_sync = sync_q[0];
  assign sdi_sync  = sync_q[1];
  assign cs_sync   = sync_q[2];

  wpr_edge #(.RST_LVL(1'b0)) u_sclk_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sclk_sync),
    .rise  (ev.sclk_rise),
    .fall  (ev.sclk_fall)
  );

  wpr_edge #(.RST_LVL(1'b1)) u_cs_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cs_sync),
    .rise  (ev.cs_rise),
    .fall  (ev.cs_fall)
  );

  assign shift_ev    = ev.sclk_rise & ~cs_sync;
  assign sdo_load_ev = (ev.sclk_fall | ev.cs_fall) & ~cs_sync;

  wpr_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .shift_ev     (shift_ev),
    .din          (sdi_sync),
    .sdo_load_ev  (sdo_load_ev),
    .sdo_release  (cs_sync),
    .shreg        (shreg),
    .sdo_pull_low (sdo_pull_low)
  );

  wpr_commit #(.WIDTH(WIDTH), .PRESET(PRESET)) u_commit (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_ev  (shift_ev),
    .cs_rise   (ev.cs_rise),
    .shreg     (shreg),
    .commit_ev (commit_ev),
    .wiper     (wiper)
  );
endmodule

// File: rtl/wpr_checker.sv
module wpr_checker #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_sync,
  input logic             sdi_sync,
  input logic             shift_ev,
  input logic             sdo_load_ev,
  input logic             commit_ev,
  input logic [WIDTH-1:0] shreg,
  input logic [WIDTH-1:0] wiper,
  input logic             sdo_pull_low
);
  assert_hold_between_commits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_ev |=> $stable(wiper));

  assert_commit_takes_shreg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |=> wiper == $past(shreg));

  assert_msb_first_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |=> shreg[0] == $past(sdi_sync));

  assert_frozen_when_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_sync |=> $stable(shreg));

  assert_released_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_sync |=> !sdo_pull_low);

  assert_sdo_shows_top_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_load_ev && !cs_sync) |=> sdo_pull_low == !$past(shreg[WIDTH-1]));

  assert_sdo_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdo_load_ev && !cs_sync) |=> $stable(sdo_pull_low));
endmodule

bind wiper_chain_loader wpr_checker #(.WIDTH(WIDTH)) u_wpr_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_sync      (cs_sync),
  .sdi_sync     (sdi_sync),
  .shift_ev     (shift_ev),
  .sdo_load_ev  (sdo_load_ev),
  .commit_ev    (commit_ev),
  .shreg        (shreg),
  .wiper        (wiper),
  .sdo_pull_low (sdo_pull_low)
);

// File: tb/wiper_chain_loader_bench.sv
`timescale 1ns/1ps
module wiper_chain_loader_bench;
  localparam int H = 6;  // system cycles per serial half period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       sdi = 1'b0;
  logic       cs_n = 1'b1;
  logic [7:0] wiper_near;
  logic [7:0] wiper_far;
  logic       pull_near;
  logic       pull_far;
  logic       far_sdi;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench reference of both shift registers and wipers
  logic [7:0] rn = 8'h00, rf = 8'h00;
  logic [7:0] en = 8'h80, ef = 8'h80;
  bit         got = 1'b0;

  always #10 clk = ~clk;

  // pull-up on the chain node
  assign far_sdi = ~pull_near;

  wiper_chain_loader u_wiper_chain_loader (
    .clk (clk), .rst_n (rst_n), .sclk (sclk), .sdi (sdi), .cs_n (cs_n),
    .wiper (wiper_near), .sdo_pull_low (pull_near)
  );

  wiper_chain_loader u_far (
    .clk (clk), .rst_n (rst_n), .sclk (sclk), .sdi (far_sdi), .cs_n (cs_n),
    .wiper (wiper_far), .sdo_pull_low (pull_far)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // the far device receives the bit that leaves the near register
  function automatic logic [15:0] chain_step(input logic [7:0] n, input logic [7:0] f,
                                             input logic b);
    return {f[6:0], n[7], n[6:0], b};
  endfunction

  task automatic put_bit(input logic b);
    logic [15:0] nxt;
    sdi = b;
    tick(H);
    sclk = 1'b1;
    if (!cs_n) begin
      nxt = chain_step(rn, rf, b);
      rf = nxt[15:8];
      rn = nxt[7:0];
      got = 1'b1;
    end
    tick(H);
    sclk = 1'b0;
  endtask

  task automatic open_frame();
    cs_n = 1'b0;
    tick(2*H);
  endtask

  task automatic commit_model();
    if (got) begin
      en = rn;
      ef = rf;
    end
    got = 1'b0;
  endtask

  task automatic close_frame(input string req);
    tick(H);
    cs_n = 1'b1;
    tick(10);
    commit_model();
    check(req, wiper_near, en);
    check(req, wiper_far, ef);
    check("R6 released", {7'd0, pull_near}, 8'd0);
  endtask

  task automatic send_frame(input int n, input logic [31:0] bits, input string req);
    open_frame();
    for (int i = n - 1; i >= 0; i--) put_bit(bits[i]);
    close_frame(req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    tick(4);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    check("R1 near wiper", wiper_near, 8'h80);
    check("R1 far wiper", wiper_far, 8'h80);
    check("R1 sdo released", {7'd0, pull_near}, 8'd0);

    // R7 + R2: 16-bit chained frame, wiper stable mid-frame
    open_frame();
    for (int i = 15; i >= 4; i--) put_bit(((16'hA53C >> i) & 16'd1) != 0);
    check("R2 near unchanged mid-frame", wiper_near, 8'h80);
    check("R2 far unchanged mid-frame", wiper_far, 8'h80);
    tick(5);
    check("R6 sdo follows top bit", {7'd0, pull_near}, {7'd0, ~rn[7]});
    for (int i = 3; i >= 0; i--) put_bit(((16'hA53C >> i) & 16'd1) != 0);
    close_frame("R7 chain");
    check("R7 far first byte", wiper_far, 8'hA5);
    check("R7 near second byte", wiper_near, 8'h3C);

    // R2 plain byte: far gets what the near device pushed out
    send_frame(8, 32'h0000_00C3, "R2 byte");
    check("R2 near byte", wiper_near, 8'hC3);

    // R3 overflow: 20 bits, last 8 kept in near
    send_frame(20, 32'h000F_1E5A, "R3 overflow");
    check("R3 near keeps last byte", wiper_near, 8'h5A);

    // R5 zero-edge window
    open_frame();
    close_frame("R5 empty window");
    check("R5 near unchanged", wiper_near, 8'h5A);

    // R4 clocks with select high are ignored, then R8 short frame
    for (int i = 0; i < 5; i++) put_bit(1'b1);
    send_frame(3, 32'h0000_0002, "R4 R8 short frame");
    check("R8 short frame value", wiper_near, 8'hD2);

    // R9 coincident rise and release
    open_frame();
    for (int i = 7; i >= 0; i--) put_bit(((8'h96 >> i) & 8'd1) != 0);
    sdi = 1'b1;
    tick(H);
    sclk = 1'b1;
    cs_n = 1'b1;
    tick(H);
    sclk = 1'b0;
    tick(10);
    commit_model();
    check("R9 near excludes coincident bit", wiper_near, 8'h96);
    check("R9 far", wiper_far, ef);

    // random frames, lengths 0..20
    for (int k = 0; k < 40; k++) begin
      int n;
      n = int'($urandom_range(20, 0));
      send_frame(n, $urandom(), "R2 R3 R8 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule